// File: doc/BRIEF.md
# Selectable Hex Source Display

This block drives an eight-digit, time-multiplexed seven-segment display with one of three 16-bit quantities, rendered in hexadecimal. The candidates are a 16-bit switch word, a free-running counter that advances on a slow periodic tick (10 Hz at a 100 MHz clock with the default parameters), and a tally of presses of a mechanical push button. The button is first filtered by a stable-time debouncer, and then only the rising edge of the clean level is counted.

Two select buttons choose what is shown. The press-tally select wins over the auto-counter select, and with neither held the switch word is shown. The chosen 16-bit value is zero-extended to 32 bits. A scanner enables one digit at a time, in turn, through active-low anode lines, and drives active-low cathode lines shared by all digits. The tick period, the debounce stability time and the per-digit dwell time are parameters. A synchronous active-low reset returns every register to its initial state.

Top module: `hexsel_display`

## Requirements
- R1: With neither `sel_auto` nor `sel_press` held, the displayed 16-bit value equals `sw_val`.
- R2: With `sel_auto` held and `sel_press` released, the displayed value is the auto counter. After N clock edges since reset is released, the auto counter equals floor(N / TICK_CYCLES) mod 65536.
- R3: With `sel_press` held, the displayed value is the press counter, whatever the state of `sel_auto`.
- R4: The periodic tick is high for exactly one cycle per TICK_CYCLES cycles. The auto counter is 16 bits wide and wraps from 0xFFFF to 0x0000.
- R5: Each debounced press adds exactly one to the press counter. Releasing the button adds nothing, and the counter changes only in the cycle after a press event.
- R6: A level on `press_btn` that lasts fewer than STABLE_CYCLES cycles never reaches the debounced output and never changes the press counter.
- R7: Exactly one bit of `dig_n` is low at any time. The enabled digit steps from index i to index (i+1) mod 8 and stays enabled for SCAN_CYCLES cycles.
- R8: The enabled digit i shows nibble i (bits 4i+3..4i) of the 32-bit display value. `seg_n` is active-low with bit 0 = segment a up to bit 6 = segment g. The lit-segment patterns in g..a order for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex).
- R9: Digits 4 to 7 always show 0, so `seg_n` is 7'h40 while any of them is enabled.
- R10: While `rst_n` is low at a clock edge, both counters clear to 0 and digit 0 becomes the enabled digit (`dig_n` = 8'hFE).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_val | input | 16 | Switch word, the default source |
| sel_auto | input | 1 | Hold to show the auto counter |
| sel_press | input | 1 | Hold to show the press counter; overrides `sel_auto` |
| press_btn | input | 1 | Raw push button whose presses are tallied |
| seg_n | output | 7 | Active-low shared cathodes, bit 0 = a to bit 6 = g |
| dig_n | output | 8 | Active-low digit enables, bit i = digit i |

## Verification
The bench builds the block with TICK_CYCLES = 2, STABLE_CYCLES = 4 and SCAN_CYCLES = 3. With these values a full eight-digit scan takes 24 cycles, and a debounced press completes in a few tens of cycles. The short tick lets the auto counter run through all 65536 values and wrap within about 131,000 cycles. The bench reads the display back digit by digit through the cathode and anode pins, and checks each digit against the source value expected at the moment that digit was sampled.

// File: rtl/hexsel_pkg.sv
// Shared types and the nibble-to-segment lookup for the hex display block.
// Assumes segment vectors are active-high, ordered {g,f,e,d,c,b,a}.
package hexsel_pkg;

    typedef enum logic [1:0] {
        SRC_SWITCH = 2'd0,
        SRC_AUTO   = 2'd1,
        SRC_PRESS  = 2'd2
    } src_sel_e;

    // Map one hex nibble to its lit-segment pattern (active-high, bit 0 = a).
    function automatic logic [6:0] nibble_to_seg(input logic [3:0] nib);
        logic [6:0] pat;
        case (nib)
            4'h0: pat = 7'h3F;
            4'h1: pat = 7'h06;
            4'h2: pat = 7'h5B;
            4'h3: pat = 7'h4F;
            4'h4: pat = 7'h66;
            4'h5: pat = 7'h6D;
            4'h6: pat = 7'h7D;
            4'h7: pat = 7'h07;
            4'h8: pat = 7'h7F;
            4'h9: pat = 7'h6F;
            4'hA: pat = 7'h77;
            4'hB: pat = 7'h7C;
            4'hC: pat = 7'h39;
            4'hD: pat = 7'h5E;
            4'hE: pat = 7'h79;
            default: pat = 7'h71;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/hexsel_tick.sv
// Periodic single-cycle pulse generator.
// Produces tick_o high for one cycle every PERIOD cycles; the first pulse
// comes PERIOD cycles after reset is released. Assumes PERIOD >= 1.
module hexsel_tick #(
    parameter int PERIOD = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase_q;

    assign tick_o = (phase_q == LAST);

    // Advance the phase counter, returning to zero on the tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/hexsel_debounce.sv
// Stable-time debouncer with a rising-edge event output.
// The clean level follows the raw input only after the input has stayed the
// same for STABLE cycles; any change restarts the count. rise_o is high for
// one cycle when the clean level goes from 0 to 1. Assumes raw_i is already
// synchronous to clk.
module hexsel_debounce #(
    parameter int STABLE = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o,
    output logic rise_o
);
    localparam int CW = $clog2(STABLE + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    logic          prev_q;
    logic [CW-1:0] hold_q;
    logic          clean_q;
    logic          clean_d_q;

    // Track how long the raw level has held and commit it once stable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            hold_q  <= '0;
            clean_q <= 1'b0;
        end else begin
            prev_q <= raw_i;
            if (raw_i != prev_q) begin
                hold_q <= '0;
            end else if (hold_q == LAST) begin
                clean_q <= prev_q;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    // Keep last cycle's clean level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_d_q <= 1'b0;
        end else begin
            clean_d_q <= clean_q;
        end
    end

    assign clean_o = clean_q;
    assign rise_o  = clean_q & ~clean_d_q;

endmodule

// File: rtl/hexsel_counter.sv
// Wrapping event counter: adds one on every clock edge where evt_i is high.
// Wraps from all-ones to zero.
module hexsel_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    output logic [WIDTH-1:0] count_o
);
    // Count events; natural overflow gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (evt_i) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/hexsel_scan.sv
// Multiplexed seven-segment scanner.
// A one-hot digit select rotates toward higher indices every DWELL cycles,
// starting at digit 0 after reset. The enabled digit shows the matching
// nibble of val_i. Outputs are active-low. Assumes DIGITS >= 2.
module hexsel_scan
    import hexsel_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int DWELL  = 100_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4*DIGITS-1:0] val_i,
    output logic [6:0]          seg_n,
    output logic [DIGITS-1:0]   dig_n
);
    localparam int CW = $clog2(DWELL + 1);
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0]     dwell_q;
    logic [DIGITS-1:0] sel_q;
    logic [3:0]        nib_arr [DIGITS];
    logic [3:0]        nib;

    // Split the display word into one nibble per digit.
    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
        assign nib_arr[g] = val_i[4*g +: 4];
    end

    // Time each digit and rotate the one-hot select at the end of its dwell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
            sel_q   <= DIGITS'(1);
        end else if (dwell_q == LAST) begin
            dwell_q <= '0;
            sel_q   <= {sel_q[DIGITS-2:0], sel_q[DIGITS-1]};
        end else begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    // Pick the nibble of the enabled digit.
    always_comb begin
        nib = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (sel_q[i]) nib = nib | nib_arr[i];
        end
    end

    assign seg_n = ~nibble_to_seg(nib);
    assign dig_n = ~sel_q;

endmodule

// File: rtl/hexsel_display.sv
// Top level: selectable hex source display.
// Chooses among a switch word, a periodic auto counter and a button-press
// counter, then shows the result, zero-extended, on a strobed display.
// Assumes all inputs are synchronous to clk; sel_press outranks sel_auto.
module hexsel_display
    import hexsel_pkg::*;
#(
    parameter int VAL_W         = 16,
    parameter int DIGITS        = 8,
    parameter int TICK_CYCLES   = 10_000_000,
    parameter int STABLE_CYCLES = 1_000_000,
    parameter int SCAN_CYCLES   = 100_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  sw_val,
    input  logic              sel_auto,
    input  logic              sel_press,
    input  logic              press_btn,
    output logic [6:0]        seg_n,
    output logic [DIGITS-1:0] dig_n
);
    localparam int DISP_W = 4 * DIGITS;

    logic             tick;
    logic             press_clean;
    logic             press_evt;
    logic [VAL_W-1:0] auto_count;
    logic [VAL_W-1:0] press_count;
    src_sel_e         src;
    logic [VAL_W-1:0] shown_val;
    logic [DISP_W-1:0] disp_val;

    hexsel_tick #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    hexsel_counter #(.WIDTH(VAL_W)) u_auto_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (tick),
        .count_o (auto_count)
    );

    hexsel_debounce #(.STABLE(STABLE_CYCLES)) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (press_btn),
        .clean_o (press_clean),
        .rise_o  (press_evt)
    );

    hexsel_counter #(.WIDTH(VAL_W)) u_press_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (press_evt),
        .count_o (press_count)
    );

    // Priority decode of the two select buttons.
    always_comb begin
        if (sel_press)     src = SRC_PRESS;
        else if (sel_auto) src = SRC_AUTO;
        else               src = SRC_SWITCH;
    end

    // Route the chosen source to the display.
    always_comb begin
        case (src)
            SRC_PRESS: shown_val = press_count;
            SRC_AUTO:  shown_val = auto_count;
            default:   shown_val = sw_val;
        endcase
    end

    assign disp_val = {{(DISP_W - VAL_W){1'b0}}, shown_val};

    hexsel_scan #(.DIGITS(DIGITS), .DWELL(SCAN_CYCLES)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .val_i (disp_val),
        .seg_n (seg_n),
        .dig_n (dig_n)
    );

endmodule

// File: rtl/hexsel_chk.sv
// Assertion checker for hexsel_display, attached by bind below.
module hexsel_chk #(
    parameter int VAL_W       = 16,
    parameter int DIGITS      = 8,
    parameter int TICK_CYCLES = 10_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              press_raw,
    input logic              press_clean,
    input logic              press_evt,
    input logic              tick,
    input logic [VAL_W-1:0]  auto_count,
    input logic [VAL_W-1:0]  press_count,
    input logic [6:0]        seg_n,
    input logic [DIGITS-1:0] dig_n
);
    // Rotate an enable vector one place toward higher digit indices.
    function automatic logic [DIGITS-1:0] rot_up(input logic [DIGITS-1:0] v);
        return {v[DIGITS-2:0], v[DIGITS-1]};
    endfunction

    // R7
    anode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~dig_n) == 1);

    // R7
    digit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dig_n) |-> dig_n == rot_up($past(dig_n)));

    // R9
    upper_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_n[DIGITS-1:DIGITS/2] != '1) |-> seg_n == 7'h40);

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && TICK_CYCLES > 1) |=> !tick);

    // R4
    auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(auto_count) |-> auto_count == VAL_W'($past(auto_count) + 1'b1));

    // R5
    press_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(press_count) |-> $past(press_evt));

    // R5
    press_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_evt |=> !press_evt);

    // R6
    clean_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(press_clean) |-> $past(press_raw) == press_clean);

endmodule

bind hexsel_display hexsel_chk #(
    .VAL_W       (VAL_W),
    .DIGITS      (DIGITS),
    .TICK_CYCLES (TICK_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .press_raw   (press_btn),
    .press_clean (press_clean),
    .press_evt   (press_evt),
    .tick        (tick),
    .auto_count  (auto_count),
    .press_count (press_count),
    .seg_n       (seg_n),
    .dig_n       (dig_n)
);

// File: tb/tb_hexsel_display.sv
`timescale 1ns / 1ps
module tb_hexsel_display;

    localparam int TICK   = 2;
    localparam int STABLE = 4;
    localparam int SCAN   = 3;
    localparam int SRC_SW = 0, SRC_AU = 1, SRC_PR = 2;

    localparam logic [6:0] SEG_TAB [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
    };

    typedef struct packed {
        logic [15:0] sw;
        logic        a;
        logic        p;
        logic [1:0]  src;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{sw: 16'hA5C3, a: 1'b0, p: 1'b0, src: 2'd0},
        '{sw: 16'h1234, a: 1'b1, p: 1'b0, src: 2'd1},
        '{sw: 16'hFFFF, a: 1'b0, p: 1'b1, src: 2'd2},
        '{sw: 16'h0F0F, a: 1'b1, p: 1'b1, src: 2'd2},
        '{sw: 16'hBEEF, a: 1'b0, p: 1'b0, src: 2'd0},
        '{sw: 16'h6789, a: 1'b1, p: 1'b0, src: 2'd1},
        '{sw: 16'h0000, a: 1'b0, p: 1'b0, src: 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sw_val = 16'h0;
    logic        sel_auto = 1'b0;
    logic        sel_press = 1'b0;
    logic        press_btn = 1'b0;
    logic [6:0]  seg_n;
    logic [7:0]  dig_n;

    int unsigned ncyc = 0;
    int          nchecks = 0;
    int          nfail = 0;
    int          press_exp = 0;
    bit          done = 1'b0;

    hexsel_display #(
        .VAL_W(16), .DIGITS(8), .TICK_CYCLES(TICK),
        .STABLE_CYCLES(STABLE), .SCAN_CYCLES(SCAN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sw_val(sw_val), .sel_auto(sel_auto),
        .sel_press(sel_press), .press_btn(press_btn),
        .seg_n(seg_n), .dig_n(dig_n)
    );

    always #5 clk = ~clk;

    // Clock edges since reset release, the reference time base for the auto counter.
    always @(posedge clk) begin
        if (!rst_n) ncyc <= 0;
        else        ncyc <= ncyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int decode(input logic [6:0] s);
        int r = 99;
        for (int k = 0; k < 16; k++) if (~s == SEG_TAB[k]) r = k;
        return r;
    endfunction

    function automatic int expect_val(input int src, input int unsigned n);
        if (src == SRC_AU) return int'((n / TICK) % 65536);
        if (src == SRC_PR) return press_exp % 65536;
        return int'(sw_val);
    endfunction

    // Read all eight digits in scan order and compare each with the value expected when it was seen.
    task automatic read_disp(input int src, input string req);
        bit ok = 1'b1;
        int act = 0, exp = 0;
        for (int i = 0; i < 8; i++) begin
            int w = 0;
            int got, want;
            @(negedge clk);
            while (dig_n != ~(8'h01 << i) && w < 64) begin
                @(negedge clk);
                w++;
            end
            got  = decode(seg_n);
            want = (i < 4) ? ((expect_val(src, ncyc) >> (4 * i)) & 15) : 0;
            if (ok && (w >= 64 || got != want)) begin
                ok  = 1'b0;
                act = (w >= 64) ? int'(dig_n) : got;
                exp = want;
            end
        end
        check(ok, req, act, exp);
    endtask

    task automatic drive_press(input int high_cycles, input int low_cycles);
        @(negedge clk) press_btn = 1'b1;
        repeat (high_cycles) @(negedge clk);
        press_btn = 1'b0;
        repeat (low_cycles) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset state at the pins
        repeat (3) @(negedge clk);
        check(dig_n == 8'hFE, "R10 digit0 in reset", int'(dig_n), 8'hFE);
        check(seg_n == 7'h40, "R10 shows 0 in reset", int'(seg_n), 7'h40);
        rst_n = 1'b1;
        read_disp(SRC_SW, "R1 switches zero after reset");

        // R5: three clean presses, each counted once
        for (int k = 0; k < 3; k++) begin
            drive_press(20, 20);
            press_exp++;
        end
        sel_press = 1'b1;
        read_disp(SRC_PR, "R5 three presses");

        // R6: short high glitch is ignored
        drive_press(2, 20);
        read_disp(SRC_PR, "R6 short glitch ignored");

        // R5/R6: a brief drop while held does not add a second count
        @(negedge clk) press_btn = 1'b1;
        repeat (20) @(negedge clk);
        press_exp++;
        press_btn = 1'b0;
        repeat (2) @(negedge clk);
        press_btn = 1'b1;
        repeat (20) @(negedge clk);
        press_btn = 1'b0;
        repeat (20) @(negedge clk);
        read_disp(SRC_PR, "R5 one count per press with release glitch");
        sel_press = 1'b0;

        // R1/R2/R3/R8/R9: stimulus table
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            sw_val    = VEC[v].sw;
            sel_auto  = VEC[v].a;
            sel_press = VEC[v].p;
            read_disp(int'(VEC[v].src), "R1/R2/R3 source select, R8 R9 encoding");
        end

        // R7: dwell length and rotation order
        begin
            logic [7:0] first;
            int dwell = 1;
            @(negedge clk);
            first = dig_n;
            while (dig_n == first) @(negedge clk);
            first = dig_n;
            @(negedge clk);
            while (dig_n == first && dwell < 64) begin
                dwell++;
                @(negedge clk);
            end
            check(dwell == SCAN, "R7 dwell cycles", dwell, SCAN);
            check(dig_n == {first[6:0], first[7]}, "R7 rotation order",
                  int'(dig_n), int'({first[6:0], first[7]}));
        end

        // R4: auto counter near the top and after wrapping
        sel_auto = 1'b1;
        sel_press = 1'b0;
        while (ncyc < 131000) @(negedge clk);
        read_disp(SRC_AU, "R4 auto counter near 0xFFFF");
        while (ncyc < 131300) @(negedge clk);
        read_disp(SRC_AU, "R4 auto counter wrapped");
        check((ncyc / TICK) % 65536 < 256, "R4 wrap window reached", int'(ncyc), 131072);

        // R10: mid-run reset clears both counters
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(dig_n == 8'hFE, "R10 digit0 after reset", int'(dig_n), 8'hFE);
        rst_n = 1'b1;
        press_exp = 0;
        sel_press = 1'b1;
        read_disp(SRC_PR, "R10 press counter cleared");
        sel_press = 1'b0;
        read_disp(SRC_AU, "R10 auto counter restarted");
        finish_run();
    end

endmodule